// File: doc/BRIEF.md
# Relative Branch Target Unit

This block holds the program counter of a processor whose instructions are all 16 bits wide. In every cycle it decides whether the current instruction's branch is taken and forms the address of the next instruction. The decoder supplies a branch kind code, a raw offset field and the four condition flags (negative, zero, overflow, carry). The unit then drives a taken indication and the next program counter. All of this is combinational from the current PC and the inputs.

Offsets count instruction words, not bytes, and they are measured from the instruction after the branch. Conditional kinds use a 9-bit signed word offset. The unconditional kind uses a 10-bit signed word offset. The word offset is sign-extended and doubled to a byte displacement, then added to PC + 2. The PC register loads the next-PC value on a clock edge when the advance enable is high. It resets to address 0.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0 (asynchronous reset). After reset is released, `pc_q` stays 0 until the first edge with `advance_en` high.
- R2: `br_kind` code 9 is the unconditional branch. It is taken whatever the flags are, and its word offset is all ten bits of `offset_field`, read as two's complement (reach -512 to +511 words).
- R3: For the conditional codes 1 to 8, the word offset is `offset_field[8:0]`, read as two's complement (reach -256 to +255 words). Bit 9 of `offset_field` is ignored.
- R4: When a branch is taken, `next_pc` = `pc_q` + 2 + (sign-extended word offset × 2), computed modulo 2^16.
- R5: When no branch is taken, `br_taken` is 0 and `next_pc` = `pc_q` + 2, modulo 2^16. Codes 0 and 10 to 15 are "no branch" and are never taken.
- R6: Code 1 is taken when Z is 1. Code 2 is taken when Z is 0.
- R7: Code 3 is taken when C is 1. Code 4 is taken when C is 0.
- R8: Code 5 is taken when N is 1. Code 6 is taken when N is 0.
- R9: Code 7 is taken when V is 1. Code 8 is taken when V is 0.
- R10: On a rising clock edge with `advance_en` high, `pc_q` takes the `next_pc` value from before the edge. With `advance_en` low, `pc_q` holds.
- R11: Bit 0 of `pc_q` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance_en | input | 1 | Load `next_pc` into the PC on this edge |
| br_kind | input | 4 | Branch kind code (see R2 to R9) |
| offset_field | input | 10 | Raw signed word offset from the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc_q | output | 16 | Current program counter |
| br_taken | output | 1 | Branch decision for the current inputs |
| next_pc | output | 16 | Address of the next instruction |

## Verification
`br_taken` and `next_pc` follow the inputs and `pc_q` in the same cycle. `pc_q` changes only at the rising edge after an enabled cycle. The one exception is reset, which clears `pc_q` at once. The bench therefore drives inputs at the falling edge and checks the combinational results 2 ns later. It checks `pc_q` 2 ns after the next rising edge, against its own running model of the PC. The reset value is checked 2 ns after `rst_n` falls, with no clock edge in between.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
   localparam int KIND_W = 4;

   typedef enum logic [KIND_W-1:0] {
      BK_NONE   = 4'd0,
      BK_EQ     = 4'd1,
      BK_NE     = 4'd2,
      BK_CS     = 4'd3,
      BK_CC     = 4'd4,
      BK_MI     = 4'd5,
      BK_PL     = 4'd6,
      BK_VS     = 4'd7,
      BK_VC     = 4'd8,
      BK_ALWAYS = 4'd9
   } br_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;
endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
   import rbu_pkg::*;
(
   input  logic [KIND_W-1:0] kind_raw,
   input  flags_t            flags,
   output logic              is_uncond,
   output logic              taken
);
   br_kind_e kind;

   always_comb begin
      kind      = br_kind_e'(kind_raw);
      is_uncond = 1'b0;
      taken     = 1'b0;
      case (kind)
         BK_EQ:     taken = flags.z;
         BK_NE:     taken = ~flags.z;
         BK_CS:     taken = flags.c;
         BK_CC:     taken = ~flags.c;
         BK_MI:     taken = flags.n;
         BK_PL:     taken = ~flags.n;
         BK_VS:     taken = flags.v;
         BK_VC:     taken = ~flags.v;
         BK_ALWAYS: begin
            taken     = 1'b1;
            is_uncond = 1'b1;
         end
         default:   taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/rbu_offset_ext.sv
module rbu_offset_ext #(
   parameter int COND_W   = 9,
   parameter int UNCOND_W = 10,
   parameter int SHIFT    = 1,
   parameter int OUT_W    = 16
) (
   input  logic [UNCOND_W-1:0] field,
   input  logic                use_wide,
   output logic [OUT_W-1:0]    disp
);
   localparam int NUM_VAR = 2;

   logic [OUT_W-1:0] scaled [NUM_VAR];

   for (genvar g = 0; g < NUM_VAR; g++) begin : g_ext
      localparam int W = (g == 0) ? COND_W : UNCOND_W;
      logic [OUT_W-1:0] sx;
      assign sx        = {{(OUT_W-W){field[W-1]}}, field[W-1:0]};
      assign scaled[g] = sx << SHIFT;
   end

   assign disp = use_wide ? scaled[1] : scaled[0];
endmodule

// File: rtl/rbu_pc_adder.sv
module rbu_pc_adder #(
   parameter int PC_W            = 16,
   parameter int SHIFT           = 1,
   parameter bit PARALLEL_TARGET = 1'b1
) (
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] disp,
   input  logic            taken,
   output logic [PC_W-1:0] next_pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << SHIFT;

   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] tgt_pc;

   assign seq_pc = pc + STEP;

   if (PARALLEL_TARGET) begin : g_par
      logic [PC_W-1:0] disp_plus_step;
      assign disp_plus_step = disp + STEP;
      assign tgt_pc         = pc + disp_plus_step;
   end else begin : g_ser
      assign tgt_pc = seq_pc + disp;
   end

   assign next_pc = taken ? tgt_pc : seq_pc;
endmodule

// File: rtl/rbu_pc_reg.sv
module rbu_pc_reg #(
   parameter int              PC_W     = 16,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PC_W-1:0] d,
   output logic [PC_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_PC;
      else if (load) q <= d;
   end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
   import rbu_pkg::*;
#(
   parameter int              PC_W            = 16,
   parameter int              COND_OFF_W      = 9,
   parameter int              UNCOND_OFF_W    = 10,
   parameter int              INSN_LOG2       = 1,
   parameter logic [PC_W-1:0] RESET_PC        = '0,
   parameter bit              PARALLEL_TARGET = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    advance_en,
   input  logic [KIND_W-1:0]       br_kind,
   input  logic [UNCOND_OFF_W-1:0] offset_field,
   input  logic                    flag_n,
   input  logic                    flag_z,
   input  logic                    flag_v,
   input  logic                    flag_c,
   output logic [PC_W-1:0]         pc_q,
   output logic                    br_taken,
   output logic [PC_W-1:0]         next_pc
);
   localparam int DISP_MAX_W = UNCOND_OFF_W + INSN_LOG2;

   if (COND_OFF_W < 1 || COND_OFF_W >= UNCOND_OFF_W) begin : g_bad_cond
      $error("conditional offset must be narrower than the unconditional offset");
   end
   if (INSN_LOG2 < 1) begin : g_bad_step
      $error("instruction size must be at least two bytes");
   end
   if (DISP_MAX_W > PC_W) begin : g_bad_pc
      $error("scaled displacement does not fit the PC width");
   end
   if ((RESET_PC % (1 << INSN_LOG2)) != 0) begin : g_bad_rst
      $error("reset address must be instruction aligned");
   end

   flags_t          flags;
   logic            is_uncond;
   logic [PC_W-1:0] disp;

   assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

   rbu_cond_eval u_cond (
      .kind_raw  (br_kind),
      .flags     (flags),
      .is_uncond (is_uncond),
      .taken     (br_taken)
   );

   rbu_offset_ext #(
      .COND_W   (COND_OFF_W),
      .UNCOND_W (UNCOND_OFF_W),
      .SHIFT    (INSN_LOG2),
      .OUT_W    (PC_W)
   ) u_ext (
      .field    (offset_field),
      .use_wide (is_uncond),
      .disp     (disp)
   );

   rbu_pc_adder #(
      .PC_W            (PC_W),
      .SHIFT           (INSN_LOG2),
      .PARALLEL_TARGET (PARALLEL_TARGET)
   ) u_add (
      .pc      (pc_q),
      .disp    (disp),
      .taken   (br_taken),
      .next_pc (next_pc)
   );

   rbu_pc_reg #(
      .PC_W     (PC_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (advance_en),
      .d     (next_pc),
      .q     (pc_q)
   );
endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            advance_en,
   input logic [3:0]      br_kind,
   input logic            flag_z,
   input logic [PC_W-1:0] pc_q,
   input logic            br_taken,
   input logic [PC_W-1:0] next_pc
);
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      advance_en |=> pc_q == $past(next_pc));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !advance_en |=> $stable(pc_q));

   p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[0] == 1'b0);

   p_always_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      br_kind == 4'd9 |-> br_taken);

   p_no_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (br_kind == 4'd0 || br_kind >= 4'd10) |-> !br_taken);

   p_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |-> next_pc == pc_q + PC_W'(2));

   p_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      br_kind == 4'd1 |-> br_taken == flag_z);
endmodule

bind rel_branch_unit rbu_checker #(.PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .advance_en (advance_en),
   .br_kind    (br_kind),
   .flag_z     (flag_z),
   .pc_q       (pc_q),
   .br_taken   (br_taken),
   .next_pc    (next_pc)
);

// File: tb/tb_rel_branch_unit.sv
module tb_rel_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        advance_en = 1'b0;
   logic [3:0]  br_kind = '0;
   logic [9:0]  offset_field = '0;
   logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
   logic [15:0] pc_q, next_pc;
   logic        br_taken;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rel_branch_unit dut (
      .clk(clk), .rst_n(rst_n), .advance_en(advance_en), .br_kind(br_kind),
      .offset_field(offset_field), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c), .pc_q(pc_q), .br_taken(br_taken),
      .next_pc(next_pc)
   );

   // {kind[4], offset[10], nzvc[4], taken[1], byte displacement[16]}
   localparam int NV = 18;
   localparam logic [34:0] TBL [NV] = '{
      {4'd0,  10'h3FF, 4'b0100, 1'b0, 16'h0000},
      {4'd1,  10'h005, 4'b0100, 1'b1, 16'h000A},
      {4'd1,  10'h005, 4'b0000, 1'b0, 16'h0000},
      {4'd2,  10'h1FF, 4'b0000, 1'b1, 16'hFFFE},
      {4'd2,  10'h010, 4'b0100, 1'b0, 16'h0000},
      {4'd3,  10'h0FF, 4'b0001, 1'b1, 16'h01FE},
      {4'd4,  10'h100, 4'b0000, 1'b1, 16'hFE00},
      {4'd4,  10'h001, 4'b0001, 1'b0, 16'h0000},
      {4'd5,  10'h203, 4'b1000, 1'b1, 16'h0006},
      {4'd6,  10'h002, 4'b1000, 1'b0, 16'h0000},
      {4'd6,  10'h002, 4'b0000, 1'b1, 16'h0004},
      {4'd7,  10'h004, 4'b0010, 1'b1, 16'h0008},
      {4'd8,  10'h004, 4'b0010, 1'b0, 16'h0000},
      {4'd8,  10'h1F0, 4'b0000, 1'b1, 16'hFFE0},
      {4'd9,  10'h1FF, 4'b1111, 1'b1, 16'h03FE},
      {4'd9,  10'h200, 4'b0000, 1'b1, 16'hFC00},
      {4'd12, 10'h3FF, 4'b1111, 1'b0, 16'h0000},
      {4'd9,  10'h3FF, 4'b0000, 1'b1, 16'hFFFE}
   };
   localparam string TAG [NV] = '{
      "R5", "R6", "R6", "R6", "R6", "R7", "R7", "R7", "R3",
      "R8", "R8", "R9", "R9", "R9", "R2", "R2", "R5", "R4"
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] k, input logic [9:0] off, input logic [3:0] nzvc,
                        input logic en);
      br_kind      = k;
      offset_field = off;
      {flag_n, flag_z, flag_v, flag_c} = nzvc;
      advance_en   = en;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] model;
      #2;
      chk("R1 reset value", pc_q, 16'h0000);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      drive(4'd9, 10'h005, 4'b0000, 1'b0);
      @(posedge clk); #2;
      chk("R1 stays 0 without advance", pc_q, 16'h0000);
      model = 16'h0000;

      for (int i = 0; i < NV; i++) begin
         logic [34:0] v;
         v = TBL[i];
         @(negedge clk);
         drive(v[34:31], v[30:21], v[20:17], 1'b1);
         #2;
         chk({TAG[i], " taken"}, {15'd0, br_taken}, {15'd0, v[16]});
         chk({TAG[i], " next_pc"}, next_pc, model + 16'd2 + v[15:0]);
         @(posedge clk); #2;
         model = model + 16'd2 + v[15:0];
         chk("R10 load", pc_q, model);
         chk("R11 aligned", {15'd0, pc_q[0]}, 16'd0);
      end

      // R10: hold while advance_en is low
      @(negedge clk);
      drive(4'd9, 10'h005, 4'b0000, 1'b0);
      #2;
      chk("R10 next_pc while held", next_pc, model + 16'd12);
      @(posedge clk); #2;
      chk("R10 hold", pc_q, model);

      // R1: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk("R1 async reset", pc_q, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: wrap below zero and back over the top
      drive(4'd9, 10'h200, 4'b0000, 1'b1);
      #2;
      chk("R4 wrap down", next_pc, 16'hFC02);
      @(posedge clk); #2;
      chk("R4 wrap down load", pc_q, 16'hFC02);
      @(negedge clk);
      drive(4'd9, 10'h1FF, 4'b0000, 1'b1);
      #2;
      chk("R4 wrap up", next_pc, 16'h0002);
      @(negedge clk);
      // R3: conditional with bit 9 set must not take the wide offset
      drive(4'd1, 10'h300, 4'b0100, 1'b0);
      #2;
      chk("R3 bit9 ignored", next_pc, 16'h0004 - 16'h0200);
      // R5: no-branch code at top of range
      drive(4'd15, 10'h0FF, 4'b1111, 1'b0);
      #2;
      chk("R5 code 15 sequential", next_pc, 16'h0004);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule